// File: doc/BRIEF.md
# Shadow Page Swap Mapper

This block keeps track of where four 8K pages of video memory currently live. Two of them form the video processor's contiguous 16K space: one page per 8K half, called video slot 0 and video slot 1. The other two appear on the CPU bus as two 8K windows, window 0 and window 1. The CPU can rewrite its windows freely. When a new frame is ready, software asks for a video slot to be exchanged with a CPU window. The page that was on the video side then becomes reachable from the CPU, and the freshly written page goes to the video processor.

Software controls the mapping through a control byte that it writes and reads one bit at a time. A video-slot bit works as an XOR mask. Its value is compared with the state the mapper has already applied, and any difference is an exchange request. An exchange is held back while the video address is inside the slot being exchanged. It takes effect on the first clock edge at which the video address is in the other half. The video processor therefore never sees a page change under an access in progress.

Both address paths are translated to 15-bit physical addresses with one registered stage each. The RAM array itself lives outside this block.

Top module: `smap_shadow_mapper`

## Requirements
- R1: After reset, video slots 0 and 1 hold physical pages 0 and 1, and CPU windows 0 and 1 hold pages 2 and 3. All control bits read 0 and `swap_pending` is 0.
- R2: On the clock edge after `vid_addr` is sampled, `vid_paddr` equals {page of video slot `vid_addr[13]`, `vid_addr[12:0]`}.
- R3: On the clock edge after `cpu_addr` is sampled, `cpu_paddr` equals {page of CPU window `cpu_addr[13]`, `cpu_addr[12:0]`}.
- R4: A write with `ctl_bit_wr`=1 at an index 0 to 3 sets that control bit to `ctl_bit_val`. Writes to indices 4 to 7 are ignored. A read at index 0 to 3 returns the bit, indices 4 to 6 read 0, and index 7 reads the pending status. `ctl_rd_bit` is registered and shows the bit one cycle after `ctl_rd_idx` is sampled.
- R5: Control bits 0 and 1 are the XOR masks for video slots 0 and 1. Control bits 2 and 3 pick the CPU window (0 or 1) that pairs with slot 0 and slot 1 respectively. When a mask bit differs from the state already applied, the mapper exchanges the pages of that slot and the chosen window, so the displaced video page appears in that CPU window.
- R6: A requested exchange for slot s commits only at a clock edge where `vid_addr[13]` differs from s. It commits at the first such edge, and until then the mapping is unchanged.
- R7: `swap_pending` (and readback index 7) is 1 exactly while at least one mask bit differs from its applied state.
- R8: Restoring a mask bit to its applied value before the exchange commits cancels the request, and no exchange takes place.
- R9: The four pages held by the two video slots and the two CPU windows are always pairwise distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_addr | input | 14 | Video processor address within its 16K space |
| vid_paddr | output | 15 | Registered physical address for the video path |
| cpu_addr | input | 14 | CPU address within its two 8K windows |
| cpu_paddr | output | 15 | Registered physical address for the CPU path |
| ctl_bit_wr | input | 1 | Control bit write strobe |
| ctl_bit_idx | input | 3 | Index of the control bit to write |
| ctl_bit_val | input | 1 | Value to write |
| ctl_rd_idx | input | 3 | Index of the control bit to read |
| ctl_rd_bit | output | 1 | Registered readback of the selected bit |
| swap_pending | output | 1 | An exchange request has not yet committed |

## Verification
The bench holds the video address inside the slot being exchanged for several cycles and checks that the CPU windows still show the old page. A design that exchanged at once would corrupt a video access in progress. It then moves the video address to the other half and expects the commit on exactly that edge. A design that waited for some other condition, or never committed, would leave `swap_pending` high. Cancellation is checked by toggling a mask bit back before the commit: a design that queued toggles would exchange the pages anyway. Writes to reserved and status indices must leave the readback unchanged. After a mix of exchanges with both windows, the four observed physical pages must still be distinct.

// File: rtl/smap_pkg.sv
`timescale 1ns/1ps
package smap_pkg;
  localparam int DEF_PAGE_AW   = 13;  // 8K page offset bits
  localparam int DEF_NUM_VSLOT = 2;   // video-side page slots
  localparam int DEF_NUM_CWIN  = 2;   // CPU-side windows
  localparam int DEF_CTL_W     = 8;   // control byte width

  // Width of an index into n items, never below one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/smap_ctl_port.sv
`timescale 1ns/1ps
// Bit-addressed control register with registered single-bit readback.
module smap_ctl_port #(
  parameter int CTL_W    = 8,
  parameter int CTL_USED = 4,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_wr,
  input  logic [IDX_W-1:0]    bit_idx,
  input  logic                bit_val,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic                pending,
  output logic [CTL_USED-1:0] ctl_q,
  output logic                rd_bit
);
  localparam int PAD_W = CTL_W - 1 - CTL_USED;

  logic [CTL_W-1:0] rd_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (bit_wr) begin
      for (int i = 0; i < CTL_USED; i++) begin
        if (bit_idx == IDX_W'(i)) ctl_q[i] <= bit_val;
      end
    end
  end

  // Top bit is the pending status; bits between are reserved zero.
  assign rd_vec = {pending, {PAD_W{1'b0}}, ctl_q};

  always_ff @(posedge clk) begin
    if (rst) rd_bit <= 1'b0;
    else     rd_bit <= rd_vec[rd_idx];
  end

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_idx >= IDX_W'(CTL_USED) && rd_idx != IDX_W'(CTL_W-1)) |=> !rd_bit); // R4

  AST_RSVD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bit_wr && bit_idx >= IDX_W'(CTL_USED)) |=> (ctl_q == $past(ctl_q))); // R4
endmodule

// File: rtl/smap_swap_ctrl.sv
`timescale 1ns/1ps
// Holds the page map and commits slot/window exchanges when the video
// side is in the other half.
module smap_swap_ctrl #(
  parameter int NUM_VSLOT = 2,
  parameter int NUM_CWIN  = 2,
  parameter int PAGE_W    = 2,
  parameter int SLOT_W    = 1,
  parameter int WSEL_W    = 1,
  parameter int CTL_USED  = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [CTL_USED-1:0]               ctl,
  input  logic [SLOT_W-1:0]                 vid_sel,
  output logic [NUM_VSLOT-1:0][PAGE_W-1:0]  vmap_q,
  output logic [NUM_CWIN-1:0][PAGE_W-1:0]   cmap_q,
  output logic                              pending
);
  localparam int NUM_PAGES = NUM_VSLOT + NUM_CWIN;

  logic [NUM_VSLOT-1:0]              applied_q;
  logic [NUM_VSLOT-1:0]              req;
  logic [NUM_VSLOT-1:0]              ok;
  logic [NUM_VSLOT-1:0]              grant;
  logic [NUM_VSLOT-1:0][WSEL_W-1:0]  win;
  logic [NUM_PAGES-1:0]              occ;

  assign req     = ctl[NUM_VSLOT-1:0] ^ applied_q;
  assign pending = |req;

  for (genvar s = 0; s < NUM_VSLOT; s++) begin : g_slot
    assign win[s] = ctl[NUM_VSLOT + s*WSEL_W +: WSEL_W];
    assign ok[s]  = req[s] && (vid_sel != SLOT_W'(s));
  end

  // Lowest eligible slot wins; one exchange per cycle.
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int s = 0; s < NUM_VSLOT; s++) begin
      if (ok[s] && !found) begin
        grant[s] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      applied_q <= '0;
      for (int s = 0; s < NUM_VSLOT; s++) vmap_q[s] <= PAGE_W'(s);
      for (int w = 0; w < NUM_CWIN; w++)  cmap_q[w] <= PAGE_W'(NUM_VSLOT + w);
    end else begin
      for (int s = 0; s < NUM_VSLOT; s++) begin
        if (grant[s]) begin
          vmap_q[s]         <= cmap_q[win[s]];
          cmap_q[win[s]]    <= vmap_q[s];
          applied_q[s]      <= ctl[s];
        end
      end
    end
  end

  always_comb begin
    occ = '0;
    for (int s = 0; s < NUM_VSLOT; s++) occ[vmap_q[s]] = 1'b1;
    for (int w = 0; w < NUM_CWIN; w++)  occ[cmap_q[w]] = 1'b1;
  end

  AST_MAP_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $countones(occ) == NUM_PAGES); // R9

  for (genvar s = 0; s < NUM_VSLOT; s++) begin : g_chk
    AST_SWAP_OTHER_HALF: assert property (@(posedge clk) disable iff (rst)
      (vmap_q[s] != $past(vmap_q[s])) |-> ($past(vid_sel) != SLOT_W'(s))); // R6
    AST_SWAP_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
      (vmap_q[s] != $past(vmap_q[s])) |-> $past(req[s])); // R5
  end
endmodule

// File: rtl/smap_xlate.sv
`timescale 1ns/1ps
// Registered address translation: slot bits select a physical page.
module smap_xlate #(
  parameter int PAGE_AW = 13,
  parameter int N       = 2,
  parameter int SLOT_W  = 1,
  parameter int PAGE_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [PAGE_AW+SLOT_W-1:0]   addr,
  input  logic [N-1:0][PAGE_W-1:0]    map,
  output logic [PAGE_AW+PAGE_W-1:0]   paddr
);
  logic [SLOT_W-1:0] slot;
  assign slot = addr[PAGE_AW +: SLOT_W];

  always_ff @(posedge clk) begin
    if (rst) paddr <= '0;
    else     paddr <= {map[slot], addr[PAGE_AW-1:0]};
  end
endmodule

// File: rtl/smap_shadow_mapper.sv
`timescale 1ns/1ps
module smap_shadow_mapper
  import smap_pkg::*;
#(
  parameter int PAGE_AW   = DEF_PAGE_AW,
  parameter int NUM_VSLOT = DEF_NUM_VSLOT,
  parameter int NUM_CWIN  = DEF_NUM_CWIN,
  parameter int CTL_W     = DEF_CTL_W
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic [PAGE_AW+idx_w(NUM_VSLOT)-1:0]           vid_addr,
  output logic [PAGE_AW+idx_w(NUM_VSLOT+NUM_CWIN)-1:0]  vid_paddr,
  input  logic [PAGE_AW+idx_w(NUM_CWIN)-1:0]            cpu_addr,
  output logic [PAGE_AW+idx_w(NUM_VSLOT+NUM_CWIN)-1:0]  cpu_paddr,
  input  logic                                          ctl_bit_wr,
  input  logic [idx_w(CTL_W)-1:0]                       ctl_bit_idx,
  input  logic                                          ctl_bit_val,
  input  logic [idx_w(CTL_W)-1:0]                       ctl_rd_idx,
  output logic                                          ctl_rd_bit,
  output logic                                          swap_pending
);
  localparam int SLOT_W   = idx_w(NUM_VSLOT);
  localparam int WSEL_W   = idx_w(NUM_CWIN);
  localparam int CWIN_W   = idx_w(NUM_CWIN);
  localparam int PAGE_W   = idx_w(NUM_VSLOT + NUM_CWIN);
  localparam int IDX_W    = idx_w(CTL_W);
  localparam int CTL_USED = NUM_VSLOT * (1 + WSEL_W);

  logic [CTL_USED-1:0]              ctl_q;
  logic [NUM_VSLOT-1:0][PAGE_W-1:0] vmap;
  logic [NUM_CWIN-1:0][PAGE_W-1:0]  cmap;

  smap_ctl_port #(
    .CTL_W(CTL_W), .CTL_USED(CTL_USED), .IDX_W(IDX_W)
  ) u_ctl (
    .clk(clk), .rst(rst),
    .bit_wr(ctl_bit_wr), .bit_idx(ctl_bit_idx), .bit_val(ctl_bit_val),
    .rd_idx(ctl_rd_idx), .pending(swap_pending),
    .ctl_q(ctl_q), .rd_bit(ctl_rd_bit)
  );

  smap_swap_ctrl #(
    .NUM_VSLOT(NUM_VSLOT), .NUM_CWIN(NUM_CWIN), .PAGE_W(PAGE_W),
    .SLOT_W(SLOT_W), .WSEL_W(WSEL_W), .CTL_USED(CTL_USED)
  ) u_swap (
    .clk(clk), .rst(rst),
    .ctl(ctl_q), .vid_sel(vid_addr[PAGE_AW +: SLOT_W]),
    .vmap_q(vmap), .cmap_q(cmap), .pending(swap_pending)
  );

  smap_xlate #(
    .PAGE_AW(PAGE_AW), .N(NUM_VSLOT), .SLOT_W(SLOT_W), .PAGE_W(PAGE_W)
  ) u_vid_xl (
    .clk(clk), .rst(rst), .addr(vid_addr), .map(vmap), .paddr(vid_paddr)
  );

  smap_xlate #(
    .PAGE_AW(PAGE_AW), .N(NUM_CWIN), .SLOT_W(CWIN_W), .PAGE_W(PAGE_W)
  ) u_cpu_xl (
    .clk(clk), .rst(rst), .addr(cpu_addr), .map(cmap), .paddr(cpu_paddr)
  );

  AST_VID_OFFSET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> vid_paddr[PAGE_AW-1:0] == $past(vid_addr[PAGE_AW-1:0])); // R2

  AST_CPU_OFFSET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cpu_paddr[PAGE_AW-1:0] == $past(cpu_addr[PAGE_AW-1:0])); // R3
endmodule

// File: tb/sim_smap_shadow_mapper.sv
`timescale 1ns/1ps
module sim_smap_shadow_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] vid_addr = '0;
  logic [14:0] vid_paddr;
  logic [13:0] cpu_addr = '0;
  logic [14:0] cpu_paddr;
  logic        ctl_bit_wr = 1'b0;
  logic [2:0]  ctl_bit_idx = '0;
  logic        ctl_bit_val = 1'b0;
  logic [2:0]  ctl_rd_idx = '0;
  logic        ctl_rd_bit;
  logic        swap_pending;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  int mv [2];
  int mc [2];
  logic [3:0] seen;

  always #2.5 clk = ~clk;

  smap_shadow_mapper u0 (
    .clk(clk), .rst(rst),
    .vid_addr(vid_addr), .vid_paddr(vid_paddr),
    .cpu_addr(cpu_addr), .cpu_paddr(cpu_paddr),
    .ctl_bit_wr(ctl_bit_wr), .ctl_bit_idx(ctl_bit_idx), .ctl_bit_val(ctl_bit_val),
    .ctl_rd_idx(ctl_rd_idx), .ctl_rd_bit(ctl_rd_bit), .swap_pending(swap_pending)
  );

  // {vid_addr, cpu_addr, expected vid_paddr, expected cpu_paddr} under reset map
  localparam logic [57:0] VEC [4] = '{
    {14'h0000, 14'h0000, 15'h0000, 15'h4000},
    {14'h1FFF, 14'h1FFF, 15'h1FFF, 15'h5FFF},
    {14'h2345, 14'h2345, 15'h2345, 15'h6345},
    {14'h3ABC, 14'h0010, 15'h3ABC, 15'h4010}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_bit(input int idx, input logic val);
    ctl_bit_wr  = 1'b1;
    ctl_bit_idx = 3'(idx);
    ctl_bit_val = val;
    tick();
    ctl_bit_wr  = 1'b0;
  endtask

  task automatic rd_bit(input int idx, output logic v);
    ctl_rd_idx = 3'(idx);
    tick();
    v = ctl_rd_bit;
  endtask

  // Only call while nothing is pending or the video address is held busy.
  task automatic check_cpu(input string req);
    for (int w = 0; w < 2; w++) begin
      cpu_addr = 14'(w * 14'h2000 + 14'h0055);
      tick();
      chk(req, 32'(cpu_paddr), 32'({2'(mc[w]), 13'h0055}));
      seen[cpu_paddr[14:13]] = 1'b1;
    end
  endtask

  // Moves the video address: only call while nothing is pending.
  task automatic check_vid(input string req);
    for (int s = 0; s < 2; s++) begin
      vid_addr = 14'(s * 14'h2000 + 14'h0AA0);
      tick();
      chk(req, 32'(vid_paddr), 32'({2'(mv[s]), 13'h0AA0}));
      seen[vid_paddr[14:13]] = 1'b1;
    end
  endtask

  task automatic xchg(input int s, input int w);
    int t;
    t = mv[s]; mv[s] = mc[w]; mc[w] = t;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic v;
    mv[0] = 0; mv[1] = 1; mc[0] = 2; mc[1] = 3;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1: reset state
    chk("R1 pending", 32'(swap_pending), 0);
    for (int i = 0; i < 8; i++) begin
      rd_bit(i, v);
      chk("R1 ctl readback", 32'(v), 0);
    end

    // R2 R3: table of translations under reset map
    for (int i = 0; i < 4; i++) begin
      vid_addr = VEC[i][57:44];
      cpu_addr = VEC[i][43:30];
      tick();
      chk("R2 vid xlate", 32'(vid_paddr), 32'(VEC[i][29:15]));
      chk("R3 cpu xlate", 32'(cpu_paddr), 32'(VEC[i][14:0]));
    end

    // R4: control bit write/readback, reserved and status indices ignored
    wr_bit(3, 1'b1);
    rd_bit(3, v);  chk("R4 bit3 set", 32'(v), 1);
    wr_bit(5, 1'b1);
    rd_bit(5, v);  chk("R4 reserved reads 0", 32'(v), 0);
    wr_bit(7, 1'b1);
    rd_bit(7, v);  chk("R4 status write ignored", 32'(v), 0);
    chk("R4 no request from window bits", 32'(swap_pending), 0);
    wr_bit(3, 1'b0);
    rd_bit(3, v);  chk("R4 bit3 cleared", 32'(v), 0);

    // R5 R6 R7: slot 0 with window 1, held off while video in half 0
    vid_addr = 14'h0100;
    wr_bit(2, 1'b1);
    wr_bit(0, 1'b1);
    tick(); tick();
    chk("R7 pending while blocked", 32'(swap_pending), 1);
    rd_bit(7, v);  chk("R7 status readback", 32'(v), 1);
    check_cpu("R6 map held while busy");
    vid_addr = 14'h2100;
    tick();
    chk("R6 commit on other half", 32'(swap_pending), 0);
    xchg(0, 1);
    check_cpu("R5 displaced page on cpu");
    check_vid("R5 new page on video");

    // R5: slot 1 with window 0
    vid_addr = 14'h3000;
    wr_bit(1, 1'b1);
    tick();
    chk("R6 slot1 held", 32'(swap_pending), 1);
    vid_addr = 14'h0000;
    tick();
    chk("R6 slot1 committed", 32'(swap_pending), 0);
    xchg(1, 0);
    check_cpu("R5 slot1 cpu map");
    check_vid("R5 slot1 vid map");

    // R8: cancel a request before it commits
    vid_addr = 14'h0000;
    wr_bit(0, 1'b0);
    chk("R7 cancel request pending", 32'(swap_pending), 1);
    wr_bit(0, 1'b1);
    chk("R8 cancel clears pending", 32'(swap_pending), 0);
    vid_addr = 14'h2000;
    tick(); tick();
    check_cpu("R8 no exchange cpu");
    check_vid("R8 no exchange vid");

    // R6: immediate commit when video is already in the other half
    vid_addr = 14'h2000;
    wr_bit(0, 1'b0);
    chk("R6 pending one cycle", 32'(swap_pending), 1);
    tick();
    chk("R6 commit next edge", 32'(swap_pending), 0);
    xchg(0, 1);
    seen = '0;
    check_cpu("R5 swap back cpu");
    check_vid("R5 swap back vid");
    chk("R9 pages distinct", 32'($countones(seen)), 4);

    // R1: reset mid-run restores the initial map
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    mv[0] = 0; mv[1] = 1; mc[0] = 2; mc[1] = 3;
    chk("R1 pending after reset", 32'(swap_pending), 0);
    rd_bit(2, v);  chk("R1 window bit cleared", 32'(v), 0);
    check_cpu("R1 cpu map after reset");
    check_vid("R1 vid map after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule